// File: doc/BRIEF.md
# Encoded-Address PHY Management Bridge

This block sits between a 16-bit host register bus and up to five embedded Ethernet PHYs. It lets the host reach every PHY management register through a single window of encoded bus addresses. The host first picks the direction by writing a mode register. It then issues one bus write whose address carries a one-hot PHY select, a page number and a register number. In write mode, the data of that bus write goes to the chosen PHY register. In read mode, the data is discarded, the chosen register is fetched, and the result waits in a data register for the host to read.

Towards the PHYs, the bridge drives a one-cycle read or write strobe for each PHY. It also drives an 8-bit register address made of the page and the register number, and a write data bus. Each PHY answers with an acknowledge pulse and, for a read, its data. Only one access is outstanding at a time. While it is in flight the bridge holds `busy` high and stalls every host transfer.

Top module: `phy_window_bridge`

## Requirements
- R1: Address 0x8028 is the mode register. A host write stores `hst_wdata[0]` into it, where 1 selects read and 0 selects write. Reading the address returns the stored bit in bit 0 and zeros in all other bits. The reset value is 0.
- R2: In write mode, a host write to an encoded address starts a write. An encoded address has bit 15 set, exactly one of bits 14:9 set at bit 9+p for PHY p (0..4), the page in bits 7:5 and the register in bits 4:0. In the cycle after acceptance, `phy_wr[p]` pulses for one cycle. During that pulse `phy_addr` = {page, register} and `phy_wdata` = the host data.
- R3: In read mode, a host write to an encoded address pulses `phy_rd[p]` instead. The write data is ignored, and no PHY write takes place.
- R4: When the selected PHY acknowledges a read, its `phy_rdata` slice (bits 16p+15:16p) is captured in the data register at 0x8029. That value stays unchanged until the next read completes, whatever other accesses take place in between.
- R5: `busy` rises on the edge that accepts an encoded access and falls on the edge on which the selected PHY acknowledges. While `busy` is high, `hst_ready` is low and no host transfer takes effect.
- R6: An address with bit 15 set that is not 0x8028 or 0x8029 is rejected in two cases: bits 14:9 are not exactly one-hot, or they select a PHY above 4. A rejected write strobes no PHY and leaves `busy` low. It raises `acc_err` for exactly the one cycle after acceptance.
- R7: An acknowledge from a PHY other than the selected one, or any acknowledge while idle, has no effect on `busy` or on the data register.
- R8: After reset, `busy`, `acc_err` and all PHY strobes are low, `hst_ready` is high, and the data register reads 0.
- R9: Host writes to addresses with bit 15 clear have no effect and raise no error. Host reads of any address other than 0x8028 and 0x8029 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_req | input | 1 | Host transfer request |
| hst_we | input | 1 | Host transfer is a write |
| hst_addr | input | 16 | Host address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, combinational from address |
| hst_ready | output | 1 | Transfer accepted at this edge when high with hst_req |
| busy | output | 1 | PHY access in flight |
| acc_err | output | 1 | One-cycle pulse for a rejected encoded address |
| phy_rd | output | 5 | Per-PHY read strobe |
| phy_wr | output | 5 | Per-PHY write strobe |
| phy_addr | output | 8 | {page, register} for the strobed PHY |
| phy_wdata | output | 16 | Write data for the strobed PHY |
| phy_ack | input | 5 | Per-PHY completion pulse |
| phy_rdata | input | 80 | Per-PHY read data, 16 bits per PHY |

## Verification
The bench builds the block with its defaults: five PHYs, a 3-bit page and a 5-bit register number. With these values all 1280 PHY registers can be covered, so the bench sweeps every one of them in write mode and again in read mode, and computes each expected word from the PHY, page and register indices. The PHY model answers PHY p after p cycles. The slow PHYs therefore hold the bridge busy long enough to test host stalls and stray acknowledges from other PHYs. A 6-bit select field paired with only five PHYs leaves bit 14 free, so the bench can drive an out-of-range select alongside the two-hot and empty selects.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [2:0] {
    AK_NONE,
    AK_MODE,
    AK_DATA,
    AK_ACCESS,
    AK_BAD
  } acc_kind_e;

  // Select field is legal when exactly one bit is set and it names an existing PHY.
  function automatic logic sel_is_legal(input logic [15:0] sel, input int unsigned n_valid);
    logic [15:0] above;
    above = sel >> n_valid;
    return ($countones(sel) == 1) && (above == 16'd0);
  endfunction

endpackage

// File: rtl/pwb_decode.sv
module pwb_decode
  import pwb_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          N_PHY     = 5,
  parameter int          SEL_LSB   = 9,
  parameter int          PA_W      = 8,
  parameter logic [15:0] CTRL_ADDR = 16'h8028,
  parameter logic [15:0] DATA_ADDR = 16'h8029
) (
  input  logic [AW-1:0]    addr,
  output acc_kind_e        kind,
  output logic [N_PHY-1:0] phy_oh,
  output logic [PA_W-1:0]  pa
);
  localparam int SEL_W = AW - 1 - SEL_LSB;

  logic [SEL_W-1:0] sel;
  logic             legal;

  assign sel    = addr[AW-2:SEL_LSB];
  assign legal  = sel_is_legal(16'(sel), N_PHY);
  assign phy_oh = sel[N_PHY-1:0];
  assign pa     = addr[PA_W-1:0];

  always_comb begin
    if (addr == AW'(CTRL_ADDR))      kind = AK_MODE;
    else if (addr == AW'(DATA_ADDR)) kind = AK_DATA;
    else if (addr[AW-1])             kind = legal ? AK_ACCESS : AK_BAD;
    else                             kind = AK_NONE;
  end

endmodule

// File: rtl/pwb_seq.sv
module pwb_seq #(
  parameter int N_PHY = 5,
  parameter int DW    = 16,
  parameter int PA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_rd,
  input  logic [N_PHY-1:0]   start_oh,
  input  logic [PA_W-1:0]    start_pa,
  input  logic [DW-1:0]      start_wd,
  input  logic [N_PHY-1:0]   phy_ack,
  input  logic [N_PHY*DW-1:0] phy_rdata,
  output logic               busy,
  output logic [N_PHY-1:0]   phy_rd,
  output logic [N_PHY-1:0]   phy_wr,
  output logic [PA_W-1:0]    phy_pa,
  output logic [DW-1:0]      phy_wd,
  output logic [N_PHY-1:0]   cur_oh,
  output logic [DW-1:0]      rd_q
);
  logic          cur_rd;
  logic          resp_hit;
  logic [DW-1:0] resp_data;

  // completion event: the PHY that was strobed answers
  assign resp_hit = busy && |(phy_ack & cur_oh);

  always_comb begin
    resp_data = '0;
    for (int i = 0; i < N_PHY; i++) begin
      if (cur_oh[i]) resp_data = resp_data | phy_rdata[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phy_rd <= '0;
      phy_wr <= '0;
      phy_pa <= '0;
      phy_wd <= '0;
      cur_oh <= '0;
      cur_rd <= 1'b0;
      rd_q   <= '0;
    end else begin
      phy_rd <= '0;
      phy_wr <= '0;
      if (start) begin
        busy   <= 1'b1;
        cur_oh <= start_oh;
        cur_rd <= start_rd;
        phy_pa <= start_pa;
        phy_wd <= start_rd ? '0 : start_wd;
        phy_rd <= start_rd ? start_oh : '0;
        phy_wr <= start_rd ? '0 : start_oh;
      end else if (resp_hit) begin
        busy <= 1'b0;
        if (cur_rd) rd_q <= resp_data;
      end
    end
  end

endmodule

// File: rtl/phy_window_bridge.sv
module phy_window_bridge
  import pwb_pkg::*;
#(
  parameter int          N_PHY     = 5,
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          PG_W      = 3,
  parameter int          RG_W      = 5,
  parameter int          SEL_LSB   = 9,
  parameter logic [15:0] CTRL_ADDR = 16'h8028,
  parameter logic [15:0] DATA_ADDR = 16'h8029
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_req,
  input  logic                hst_we,
  input  logic [AW-1:0]       hst_addr,
  input  logic [DW-1:0]       hst_wdata,
  output logic [DW-1:0]       hst_rdata,
  output logic                hst_ready,
  output logic                busy,
  output logic                acc_err,
  output logic [N_PHY-1:0]    phy_rd,
  output logic [N_PHY-1:0]    phy_wr,
  output logic [PG_W+RG_W-1:0] phy_addr,
  output logic [DW-1:0]       phy_wdata,
  input  logic [N_PHY-1:0]    phy_ack,
  input  logic [N_PHY*DW-1:0] phy_rdata
);
  localparam int PA_W = PG_W + RG_W;

  acc_kind_e        kind;
  logic [N_PHY-1:0] dec_oh;
  logic [PA_W-1:0]  dec_pa;
  logic             wr_accept;
  logic             start_acc;
  logic             mode_q;
  logic [DW-1:0]    rd_q;
  logic [N_PHY-1:0] cur_oh;

  pwb_decode #(
    .AW(AW), .N_PHY(N_PHY), .SEL_LSB(SEL_LSB), .PA_W(PA_W),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr(hst_addr), .kind(kind), .phy_oh(dec_oh), .pa(dec_pa)
  );

  assign hst_ready = !busy;
  assign wr_accept = hst_req && hst_ready && hst_we;
  assign start_acc = wr_accept && (kind == AK_ACCESS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      acc_err <= 1'b0;
    end else begin
      acc_err <= wr_accept && (kind == AK_BAD);
      if (wr_accept && kind == AK_MODE) mode_q <= hst_wdata[0];
    end
  end

  pwb_seq #(.N_PHY(N_PHY), .DW(DW), .PA_W(PA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start_acc), .start_rd(mode_q), .start_oh(dec_oh),
    .start_pa(dec_pa), .start_wd(hst_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata),
    .busy(busy), .phy_rd(phy_rd), .phy_wr(phy_wr),
    .phy_pa(phy_addr), .phy_wd(phy_wdata),
    .cur_oh(cur_oh), .rd_q(rd_q)
  );

  always_comb begin
    case (kind)
      AK_MODE: hst_rdata = {{(DW-1){1'b0}}, mode_q};
      AK_DATA: hst_rdata = rd_q;
      default: hst_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int          N_PHY     = 5,
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter logic [15:0] CTRL_ADDR = 16'h8028
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_req,
  input logic             hst_we,
  input logic [AW-1:0]    hst_addr,
  input logic             ctrl_bit,
  input logic             hst_ready,
  input logic             busy,
  input logic             acc_err,
  input logic [N_PHY-1:0] phy_rd,
  input logic [N_PHY-1:0] phy_wr,
  input logic [N_PHY-1:0] phy_ack,
  input logic             mode_q,
  input logic [DW-1:0]    rd_q,
  input logic [N_PHY-1:0] cur_oh
);

  // R1
  mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req && hst_ready && hst_we && hst_addr == AW'(CTRL_ADDR)) |=> (mode_q == $past(ctrl_bit)));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_rd | phy_wr) && ((phy_rd & phy_wr) == '0));

  // R5
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(phy_rd | phy_wr)) |-> busy);

  // R5
  stall_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (!busy && (phy_rd | phy_wr) == '0));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(|(phy_ack & cur_oh)));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && |(phy_ack & cur_oh)) |=> $stable(rd_q));

endmodule

bind phy_window_bridge pwb_checker #(
  .N_PHY(N_PHY), .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
  .hst_addr(hst_addr), .ctrl_bit(hst_wdata[0]), .hst_ready(hst_ready),
  .busy(busy), .acc_err(acc_err), .phy_rd(phy_rd), .phy_wr(phy_wr),
  .phy_ack(phy_ack), .mode_q(mode_q), .rd_q(rd_q), .cur_oh(cur_oh)
);

// File: tb/sim_phy_window_bridge.sv
module sim_phy_window_bridge;
  localparam int NP = 5;
  localparam logic [15:0] CTRL = 16'h8028;
  localparam logic [15:0] DATA = 16'h8029;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, hst_req, hst_we, hst_ready, busy, acc_err;
  logic [15:0]    hst_addr, hst_wdata, hst_rdata;
  logic [NP-1:0]  phy_rd, phy_wr, phy_ack, ack_m, spur;
  logic [7:0]     phy_addr;
  logic [15:0]    phy_wdata;
  logic [NP*16-1:0] phy_rdata;

  int n_chk = 0;
  int n_bad = 0;

  phy_window_bridge u0 (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_ready(hst_ready), .busy(busy), .acc_err(acc_err),
    .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  // PHY model: PHY p answers p cycles after its strobe
  logic [15:0] mem [0:NP*256-1];
  logic [15:0] rdm [0:NP-1];
  int          cnt [0:NP-1];
  logic [7:0]  pend [0:NP-1];
  int wr_cnt = 0, rd_cnt = 0, last_p = -1;
  logic [7:0]  last_pa;
  logic [15:0] last_wd;

  initial begin
    for (int p = 0; p < NP; p++) begin cnt[p] = 0; rdm[p] = '0; pend[p] = '0; end
    for (int i = 0; i < NP*256; i++) mem[i] = '0;
    ack_m = '0;
  end

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      ack_m[p] = 1'b0;
      if (cnt[p] > 0) begin
        cnt[p] = cnt[p] - 1;
        if (cnt[p] == 0) begin ack_m[p] = 1'b1; rdm[p] = mem[p*256 + int'(pend[p])]; end
      end
      if (phy_wr[p] || phy_rd[p]) begin
        pend[p] = phy_addr;
        if (phy_wr[p]) begin
          mem[p*256 + int'(phy_addr)] = phy_wdata;
          wr_cnt++; last_p = p; last_pa = phy_addr; last_wd = phy_wdata;
        end else rd_cnt++;
        if (p == 0) begin ack_m[p] = 1'b1; rdm[p] = mem[int'(phy_addr)]; end
        else cnt[p] = p;
      end
    end
  end

  assign phy_ack = ack_m | spur;
  for (genvar g = 0; g < NP; g++) begin : g_rd
    assign phy_rdata[g*16 +: 16] = rdm[g];
  end

  function automatic logic [15:0] enc(int p, int pg, int r);
    return 16'h8000 + 16'(2 ** (9 + p)) + 16'(pg * 32 + r);
  endfunction

  function automatic logic [15:0] pat(int p, int pg, int r);
    return 16'(p * 7919 + pg * 613 + r * 97 + 1234);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic last_err;

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input bit wait_idle);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    #1;
    while (!hst_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    last_err = acc_err;
    hst_req = 1'b0; hst_we = 1'b0;
    if (wait_idle) begin
      while (busy) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b0; hst_addr = a;
    #1;
    while (!hst_ready) begin @(negedge clk); #1; end
    d = hst_rdata;
    @(negedge clk);
    hst_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int pre;
    rst_n = 1'b0; hst_req = 1'b0; hst_we = 1'b0; hst_addr = '0; hst_wdata = '0; spur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(!busy && hst_ready && !acc_err, "R8", {busy, hst_ready, acc_err}, 3'b010);
    chk((phy_rd | phy_wr) == '0, "R8", 32'(phy_rd | phy_wr), 0);
    bus_rd(DATA, v); chk(v == 16'd0, "R8", v, 0);
    // R1 mode register
    bus_rd(CTRL, v); chk(v == 16'd0, "R1", v, 0);
    bus_wr(CTRL, 16'h0001, 1'b1); bus_rd(CTRL, v); chk(v == 16'd1, "R1", v, 1);
    bus_wr(CTRL, 16'hfffe, 1'b1); bus_rd(CTRL, v); chk(v == 16'd0, "R1", v, 0);

    // R2 write sweep over every PHY register
    for (int p = 0; p < NP; p++)
      for (int pg = 0; pg < 8; pg++)
        for (int r = 0; r < 32; r++) begin
          pre = wr_cnt;
          bus_wr(enc(p, pg, r), pat(p, pg, r), 1'b1);
          chk(wr_cnt == pre + 1 && last_p == p && last_pa == 8'(pg * 32 + r) && last_wd == pat(p, pg, r),
              "R2", {last_p[7:0], last_pa, last_wd}, {8'(p), 8'(pg * 32 + r), pat(p, pg, r)});
        end

    // R3/R4 read sweep; host data is the complement and must be ignored
    bus_wr(CTRL, 16'h0001, 1'b1);
    pre = wr_cnt;
    for (int p = 0; p < NP; p++)
      for (int pg = 0; pg < 8; pg++)
        for (int r = 0; r < 32; r++) begin
          bus_wr(enc(p, pg, r), ~pat(p, pg, r), 1'b1);
          bus_rd(DATA, v);
          chk(v == pat(p, pg, r), "R4", v, pat(p, pg, r));
        end
    chk(wr_cnt == pre, "R3", wr_cnt, pre);
    chk(rd_cnt == NP * 256, "R3", rd_cnt, NP * 256);

    // R5 stall on slow PHY 4, R7 stray ack from PHY 2 while busy
    bus_wr(enc(4, 3, 7), 16'h0000, 1'b0);
    chk(busy && !hst_ready, "R5", {busy, hst_ready}, 2'b10);
    @(negedge clk); spur = 5'b00100;
    @(negedge clk); spur = '0;
    chk(busy, "R7", busy, 1);
    bus_rd(DATA, v);
    chk(v == pat(4, 3, 7), "R5", v, pat(4, 3, 7));

    // R4 retention across a write access
    bus_wr(CTRL, 16'h0000, 1'b1);
    bus_wr(enc(1, 2, 3), 16'hbeef, 1'b1);
    bus_rd(DATA, v); chk(v == pat(4, 3, 7), "R4", v, pat(4, 3, 7));

    // R6 rejected selects: two-hot, empty, PHY 5
    pre = wr_cnt + rd_cnt;
    bus_wr(16'h8000 | (16'd3 << 9), 16'h1111, 1'b0);
    chk(last_err == 1'b1, "R6", last_err, 1);
    @(negedge clk); chk(!acc_err && !busy, "R6", {acc_err, busy}, 0);
    bus_wr(16'h8000 | 16'd5, 16'h2222, 1'b0);
    chk(last_err == 1'b1, "R6", last_err, 1);
    bus_wr(16'hc000 | 16'd9, 16'h3333, 1'b0);
    chk(last_err == 1'b1, "R6", last_err, 1);
    repeat (2) @(negedge clk);
    chk(wr_cnt + rd_cnt == pre, "R6", wr_cnt + rd_cnt, pre);

    // R9 outside the window
    bus_wr(16'h0200 | 16'd5, 16'h4444, 1'b0);
    chk(last_err == 1'b0, "R9", last_err, 0);
    repeat (2) @(negedge clk);
    chk(wr_cnt + rd_cnt == pre && !busy, "R9", wr_cnt + rd_cnt, pre);
    bus_rd(16'h1234, v); chk(v == 16'd0, "R9", v, 0);
    bus_rd(enc(0, 0, 0), v); chk(v == 16'd0, "R9", v, 0);

    // R7 stray acks while idle
    @(negedge clk); spur = '1;
    @(negedge clk); spur = '0;
    chk(!busy, "R7", busy, 0);
    bus_rd(DATA, v); chk(v == pat(4, 3, 7), "R7", v, pat(4, 3, 7));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule